// File: doc/BRIEF.md
# Dual watchdog timer unit

This block holds two independent watchdog timers behind a 32-bit register port. Each timer keeps a 15-bit up-counter and a 15-bit expiry threshold. A shared prescaler divides the system clock down to one tick per 10 ms, and every timer advances by one on each tick. Software keeps a timer from expiring by writing its register often enough. A write reloads the control bit and the threshold, and it clears the running count.

Expiry means the count has reached a nonzero threshold. After expiry the count holds at that value. Timer 0 can then request a chip reset, which the block issues as a pulse of fixed length. Timer 1 can then raise a level output that tells the switch to discard packets bound for the CPU and to turn off flow control on every port. That output stays up until software writes timer 1 again. A threshold of zero turns expiry off, so after reset neither action can fire until software sets a threshold.

Top module: `wdt_unit`

## Requirements
- R1: Timer 0 is read and written at byte offset 0xC0 and timer 1 at 0xC4. A read returns the control bit in bit 31, the threshold in bits 30:16, zero in bit 15 and the count in bits 14:0. Any other offset reads zero, and a write to any other offset changes nothing.
- R2: The prescaler produces one tick every `TICK_CYCLES` clocks, and each timer's count rises by exactly one per tick.
- R3: A write to a timer register loads bit 31 and bits 30:16 and sets the count to zero. Count bits in the written word are ignored. A write takes precedence over a tick in the same cycle.
- R4: With a nonzero threshold, the count stops at the threshold and stays there until the next write.
- R5: With a threshold of zero, the timer never expires and neither output is raised, while the count keeps advancing.
- R6: When timer 0 has bit 31 set and its count reaches the threshold, `resetReq` rises in that same cycle and stays high for exactly `PULSE_CYCLES` cycles.
- R7: When timer 0 has bit 31 clear, expiry raises no reset request.
- R8: When timer 1 has bit 31 set and its count equals its nonzero threshold, `protectDrop` is high. It stays high until a write to timer 1 drops it, and that write takes effect in the cycle after the write edge.
- R9: When timer 1 has bit 31 clear, `protectDrop` stays low even after expiry.
- R10: After reset, both registers read zero and both outputs are low.
- R11: A write to one timer leaves the other timer's fields and count untouched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| regAddr | input | 8 | Byte offset of the register access |
| regWrEn | input | 1 | Write strobe for one cycle |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for `regAddr`, combinational |
| resetReq | output | 1 | Reset request pulse from timer 0 |
| protectDrop | output | 1 | Level that tells the switch to drop CPU-bound traffic and disable flow control |

## Verification
The bench targets three timing corner cases:
- A write landing on the same edge as a prescaler tick. A design that lets the tick win would read back a count of one instead of zero.
- The count holding at the threshold. A wrapping counter would leave the threshold and drop `protectDrop`.
- The exact length of the reset pulse. An off-by-one in the pulse counter would be one cycle too long or too short.

The bench also checks two things that must not happen. A zero threshold or a clear action bit must never fire an output, and a write at an unrelated offset or to the other timer must disturb neither timer.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int NUM_TMR = 2;

  typedef struct packed {
    logic               tick;
    logic [NUM_TMR-1:0] wrHit;
  } wdtStrobe_t;
endpackage

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int TICK_CYCLES = 1000000,
  parameter int ADDR_W      = 8,
  parameter int BASE_ADDR   = 'hC0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWrEn,
  output wdtStrobe_t         strobe,
  output logic [NUM_TMR-1:0] rdSel
);
  localparam int PRE_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_CYCLES - 1);

  logic [PRE_W-1:0] preCnt;
  logic             tickNow;

  assign tickNow = (preCnt == PRE_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) preCnt <= '0;
    else if (tickNow) preCnt <= '0;
    else preCnt <= preCnt + 1'b1;
  end

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_dec
    assign rdSel[t]        = (regAddr == ADDR_W'(BASE_ADDR + 4 * t));
    assign strobe.wrHit[t] = regWrEn && rdSel[t];
  end

  assign strobe.tick = tickNow;

  if (TICK_CYCLES > 1) begin : g_tick_chk
    // R2: the tick lasts a single cycle
    p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      strobe.tick |=> !strobe.tick);
  end
endmodule

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int CNT_W        = 15,
  parameter int PULSE_CYCLES = 16,
  parameter int DATA_W       = 2 * CNT_W + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  wdtStrobe_t         strobe,
  input  logic [NUM_TMR-1:0] rdSel,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  output logic               resetReq,
  output logic               protectDrop
);
  localparam int THR_LSB = CNT_W + 1;
  localparam int PULSE_W = $clog2(PULSE_CYCLES + 1);

  logic [NUM_TMR-1:0]            act;
  logic [NUM_TMR-1:0][CNT_W-1:0] thr;
  logic [NUM_TMR-1:0][CNT_W-1:0] cnt;
  logic [NUM_TMR-1:0][CNT_W-1:0] limit;
  logic [NUM_TMR-1:0]            expired;
  logic [NUM_TMR-1:0]            hit;
  logic [PULSE_W-1:0]            pulseCnt;

  always_comb begin
    for (int t = 0; t < NUM_TMR; t++) begin
      limit[t]   = (thr[t] == '0) ? {CNT_W{1'b1}} : thr[t];
      expired[t] = (thr[t] != '0) && (cnt[t] == thr[t]);
      hit[t]     = strobe.tick && !strobe.wrHit[t] && (thr[t] != '0)
                   && (cnt[t] == thr[t] - 1'b1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act <= '0;
      thr <= '0;
      cnt <= '0;
    end else begin
      for (int t = 0; t < NUM_TMR; t++) begin
        if (strobe.wrHit[t]) begin
          act[t] <= wrData[DATA_W-1];
          thr[t] <= wrData[THR_LSB +: CNT_W];
          cnt[t] <= '0;
        end else if (strobe.tick && (cnt[t] != limit[t])) begin
          cnt[t] <= cnt[t] + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulseCnt <= '0;
    else if (hit[0] && act[0]) pulseCnt <= PULSE_W'(PULSE_CYCLES);
    else if (pulseCnt != '0) pulseCnt <= pulseCnt - 1'b1;
  end

  assign resetReq    = (pulseCnt != '0);
  assign protectDrop = act[1] & expired[1];

  always_comb begin
    rdData = '0;
    for (int t = 0; t < NUM_TMR; t++)
      if (rdSel[t]) rdData = rdData | {act[t], thr[t], 1'b0, cnt[t]};
  end

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_chk
    p_write_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
      strobe.wrHit[t] |=> (cnt[t] == '0));
    p_count_bounded_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (thr[t] != '0) |-> (cnt[t] <= thr[t]));
    p_count_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!strobe.tick && !strobe.wrHit[t]) |=> $stable(cnt[t]));
  end

  p_pulse_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resetReq) |-> (expired[0] && act[0]));
  p_drop_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (protectDrop && !strobe.wrHit[1]) |=> protectDrop);
endmodule

// File: rtl/wdt_unit.sv
module wdt_unit
  import wdt_pkg::*;
#(
  parameter int TICK_CYCLES  = 1000000,
  parameter int PULSE_CYCLES = 16,
  parameter int CNT_W        = 15,
  parameter int ADDR_W       = 8,
  parameter int BASE_ADDR    = 'hC0,
  localparam int REG_W       = 2 * CNT_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  output logic              resetReq,
  output logic              protectDrop
);
  wdtStrobe_t         strobe;
  logic [NUM_TMR-1:0] rdSel;

  wdt_ctrl #(
    .TICK_CYCLES(TICK_CYCLES),
    .ADDR_W     (ADDR_W),
    .BASE_ADDR  (BASE_ADDR)
  ) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .regAddr(regAddr),
    .regWrEn(regWrEn),
    .strobe (strobe),
    .rdSel  (rdSel)
  );

  wdt_datapath #(
    .CNT_W       (CNT_W),
    .PULSE_CYCLES(PULSE_CYCLES),
    .DATA_W      (REG_W)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .rdSel      (rdSel),
    .wrData     (regWrData),
    .rdData     (regRdData),
    .resetReq   (resetReq),
    .protectDrop(protectDrop)
  );
endmodule

// File: tb/tb_wdt_unit.sv
module tb_wdt_unit;
  localparam int CLK_PERIOD = 10;
  localparam int TICK       = 4;
  localparam int PULSE      = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        resetReq;
  logic        protectDrop;

  int nTests = 0;
  int nFail  = 0;
  int rstHigh = 0;
  bit finished = 0;

  // behavioural reference state
  int mPre = 0;
  int mAct[2] = '{0, 0};
  int mThr[2] = '{0, 0};
  int mCnt[2] = '{0, 0};
  int mPulse = 0;

  wdt_unit #(.TICK_CYCLES(TICK), .PULSE_CYCLES(PULSE)) dut (
    .clk(clk), .rst_n(rst_n), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData),
    .resetReq(resetReq), .protectDrop(protectDrop)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) begin
      mPre = 0; mPulse = 0;
      for (int t = 0; t < 2; t++) begin mAct[t] = 0; mThr[t] = 0; mCnt[t] = 0; end
    end else begin
      bit tk;
      tk = (mPre == TICK - 1);
      mPre = tk ? 0 : mPre + 1;
      if (mPulse > 0) mPulse = mPulse - 1;
      for (int t = 0; t < 2; t++) begin
        if (regWrEn && regAddr == 8'hC0 + 8'(4 * t)) begin
          mAct[t] = int'(regWrData[31]);
          mThr[t] = int'(regWrData[30:16]);
          mCnt[t] = 0;
        end else if (tk) begin
          int lim;
          lim = (mThr[t] == 0) ? 32767 : mThr[t];
          if (mCnt[t] != lim) begin
            mCnt[t] = mCnt[t] + 1;
            if (t == 0 && mThr[t] != 0 && mCnt[t] == mThr[t] && mAct[t] == 1)
              mPulse = PULSE;
          end
        end
      end
    end
  end

  function automatic logic [31:0] expRd(logic [7:0] a);
    for (int t = 0; t < 2; t++)
      if (a == 8'hC0 + 8'(4 * t))
        return {mAct[t][0], mThr[t][14:0], 1'b0, mCnt[t][14:0]};
    return 32'h0;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R1", regRdData, expRd(regAddr));
      chk("R6", 32'(resetReq), 32'(mPulse != 0));
      chk("R8", 32'(protectDrop),
          32'(mAct[1] == 1 && mThr[1] != 0 && mCnt[1] == mThr[1]));
      if (resetReq) rstHigh++;
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(posedge clk); #1;
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(posedge clk); #1;
    regWrEn = 1'b0;
  endtask

  task automatic rdAt(logic [7:0] a, output logic [31:0] v);
    regAddr = a;
    @(negedge clk);
    v = regRdData;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    logic [31:0] v, v2;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R10: reset state
    rdAt(8'hC0, v); chk("R10", v, 32'h0);
    chk("R10", 32'({resetReq, protectDrop}), 32'h0);
    @(posedge clk); #1;
    rdAt(8'hC4, v); chk("R10", v, 32'h0);

    // R5: zero threshold counts but never fires
    idle(40);
    rdAt(8'hC0, v); chk("R5", 32'(v[14:0] != 0), 32'h1);
    chk("R5", 32'({resetReq, protectDrop}), 32'h0);
    wr(8'hC4, 32'h8000_0000);
    idle(40);
    chk("R5", 32'(protectDrop), 32'h0);

    // R1/R3: load, count bits ignored, count cleared
    rstHigh = 0;
    rdAt(8'hC4, v2);
    wr(8'hC0, 32'h8006_7FFF);
    rdAt(8'hC0, v); chk("R3", v, 32'h8006_0000);
    @(posedge clk); #1;
    rdAt(8'hC4, v); chk("R11", 32'(v[14:0] >= v2[14:0]), 32'h1);
    wr(8'hC4, 32'h0003_0000);

    // R4: saturation; R6 pulse length; R9 drop gated by control bit
    idle(40);
    rdAt(8'hC0, v); chk("R4", v, 32'h8006_0006);
    @(posedge clk); #1;
    rdAt(8'hC4, v); chk("R4", v, 32'h0003_0003);
    chk("R9", 32'(protectDrop), 32'h0);
    chk("R6", 32'(rstHigh), 32'(PULSE));

    // R7: timer 0 without action; R8: timer 1 with action
    wr(8'hC4, 32'h8002_0000);
    wr(8'hC0, 32'h0002_0000);
    rstHigh = 0;
    rdAt(8'hC4, v); chk("R11", 32'(v[31:16]), 32'h8002);
    @(posedge clk); #1;
    idle(20);
    chk("R7", 32'(rstHigh), 32'h0);
    rdAt(8'hC4, v); chk("R8", v, 32'h8002_0002);
    chk("R8", 32'(protectDrop), 32'h1);

    // R1: write to another offset changes nothing
    wr(8'h10, 32'hFFFF_FFFF);
    rdAt(8'h10, v); chk("R1", v, 32'h0);
    @(posedge clk); #1;
    rdAt(8'hC4, v); chk("R1", v, 32'h8002_0002);
    chk("R8", 32'(protectDrop), 32'h1);

    // R8: write to timer 1 drops the level
    wr(8'hC4, 32'h8002_0000);
    rdAt(8'hC4, v); chk("R8", 32'(protectDrop), 32'h0);
    chk("R3", v, 32'h8002_0000);

    // R3: write wins over a coincident tick at every prescaler phase
    for (int k = 0; k < 8; k++) begin
      wr(8'hC0, 32'h0004_0000);
      rdAt(8'hC0, v); chk("R3", v, 32'h0004_0000);
      repeat (k % 3) @(posedge clk);
      #1;
    end

    // R2: exactly one increment per TICK clocks
    wr(8'hC0, 32'h0100_0000);
    rdAt(8'hC0, v2);
    repeat (5 * TICK) @(negedge clk);
    v = regRdData;
    chk("R2", 32'(v[14:0] - v2[14:0]), 32'h5);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nTests++; nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule